// File: doc/BRIEF.md
# Lockable Fully Associative Line Cache

This block is a small fully associative cache between an instruction/data fetch path and a slow memory. It has sixteen lines. Each line holds four 32-bit words and a tag made of the line address (address bits [31:4]) and three attributes: valid, lock and an instruction/data type bit. A lookup is decided combinationally in the cycle it is presented. A hit returns the addressed word in that same cycle. A miss starts a four-beat fill from a memory-side interface into a victim line. The victim is the least recently used line that is not locked.

Tags and masks are written through a direct port. Writing a tag with lock set and valid clear asks the block to preload that line. The block fetches the line at the tag address and then marks it valid. Lines 10 and 11 each have an address-mask register. Address bits under set mask bits are left out of the compare, so one cached line answers at several regularly spaced addresses. If every line is locked, a miss still fetches from memory and returns the requested word, but no line is written.

Top module: `lc_cache`

## Requirements
- R1: After reset, no line is valid, `lk_ready` is high, `mem_req` is low, and the first lookup misses.
- R2: A lookup hits in the cycle it is presented when a valid line's tag equals address bits [31:4] and its type bit equals `lk_instr`. `lk_rdata` is then word `lk_addr[3:2]` of that line.
- R3: A miss drives `mem_req` with `mem_addr` set to the 16-byte aligned line address. The block accepts four `mem_beat` words in order, word 0 first. One cycle after the fourth beat, `rsp_valid` pulses with the requested word. The line then hits.
- R4: A line whose valid bit is clear never hits. It is refilled on a later miss and becomes valid again.
- R5: The victim is the least recently used unlocked line. Every hit and every completed allocating fill makes that line the most recently used.
- R6: A locked line is never chosen as a victim and keeps hitting through any number of misses.
- R7: A tag write with lock=1 and valid=0 makes the block fetch that line at the tag address and then mark it valid. `lk_ready` stays low until this is done. The preload gives no `rsp_valid`.
- R8: The mask registers exist only for lines 10 and 11. Mask bit k drops address bit k+4 from the compare. Mask writes to any other line have no effect.
- R9: When all lines are locked, a miss still fetches the line and returns the requested word on `rsp_valid`, but allocates nothing. The same address misses again.
- R10: A lookup whose `lk_instr` differs from the type bit of an otherwise matching line is a miss.
- R11: While a fill is in progress, `lk_ready` is low and lookups are ignored: there is no hit and no new fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_instr | input | 1 | Lookup type: 1 instruction, 0 data |
| lk_ready | output | 1 | Block idle with no preload pending; lookups accepted |
| lk_hit | output | 1 | Combinational hit for the presented lookup |
| lk_rdata | output | 32 | Hit word (zero when no hit) |
| rsp_valid | output | 1 | One-cycle pulse: miss word available |
| rsp_data | output | 32 | Requested word of a completed miss |
| tw_en | input | 1 | Tag write strobe (use while `lk_ready` is high) |
| tw_line | input | 4 | Line index for the tag write |
| tw_tag | input | 28 | Line address bits [31:4] |
| tw_valid | input | 1 | Valid attribute written |
| tw_lock | input | 1 | Lock attribute written |
| tw_instr | input | 1 | Type attribute written |
| mw_en | input | 1 | Mask write strobe |
| mw_line | input | 4 | Line index for the mask write |
| mw_mask | input | 28 | Mask; bit k excludes address bit k+4 |
| mem_req | output | 1 | Fill in progress, beats wanted |
| mem_addr | output | 32 | Line base address of the fill |
| mem_beat | input | 1 | Memory word valid this cycle |
| mem_rdata | input | 32 | Memory word, delivered in order word 0 to word 3 |

## Verification
The bound checker watches properties that must hold in every cycle. A hit only happens on an accepted lookup. The memory request never overlaps `lk_ready`. The fill address is line-aligned and does not change during a fill. A response always follows a memory beat. The chosen victim is never a locked line. The replacement order, the aliasing through the mask of lines 10 and 11, the preload started by a lock-without-valid tag, and the pass-through when every line is locked depend on history over many lookups. Only the bench scenarios show those, by observing which addresses hit and which fills memory sees.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int unsigned LC_AW    = 32;
    localparam int unsigned LC_DW    = 32;
    localparam int unsigned LC_WORDS = 4;
    localparam int unsigned LC_WSELW = $clog2(LC_WORDS);
    localparam int unsigned LC_OFFW  = LC_WSELW + $clog2(LC_DW / 8);
    localparam int unsigned LC_TAGW  = LC_AW - LC_OFFW;

    typedef struct packed {
        logic               valid;
        logic               lock;
        logic               instr;
        logic [LC_TAGW-1:0] tag;
    } lc_tag_t;

    typedef enum logic {FC_IDLE, FC_FILL} fc_state_t;

    // Line compare: masked-out address bits never take part.
    function automatic logic line_match(lc_tag_t t, logic [LC_TAGW-1:0] msk,
                                        logic [LC_TAGW-1:0] atag, logic instr);
        return t.valid && (t.instr == instr) && (((t.tag ^ atag) & ~msk) == '0);
    endfunction
endpackage

// File: rtl/lc_tag_match.sv
module lc_tag_match
    import lc_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned MASK_A = 10,
    parameter int unsigned MASK_B = 11,
    localparam int unsigned IDXW  = $clog2(LINES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  lc_tag_t [LINES-1:0]        tags,
    input  logic [LC_TAGW-1:0]         lk_tag,
    input  logic                       lk_instr,
    input  logic                       mw_en,
    input  logic [IDXW-1:0]            mw_line,
    input  logic [LC_TAGW-1:0]         mw_mask,
    output logic                       hit_any,
    output logic [IDXW-1:0]            hit_idx
);
    logic [LINES-1:0] match;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [LC_TAGW-1:0] msk;
        if (i == MASK_A || i == MASK_B) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst)                                  msk <= '0;
                else if (mw_en && mw_line == IDXW'(i))    msk <= mw_mask;
            end
        end else begin : g_nomask
            assign msk = '0;
        end
        assign match[i] = line_match(tags[i], msk, lk_tag, lk_instr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--)
            if (match[i]) hit_idx = IDXW'(i);
    end
    assign hit_any = |match;
endmodule

// File: rtl/lc_lru.sv
module lc_lru #(
    parameter int unsigned LINES = 16,
    localparam int unsigned IDXW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDXW-1:0]  touch_idx,
    input  logic [LINES-1:0] lock_vec,
    output logic [IDXW-1:0]  victim_idx,
    output logic             victim_ok
);
    // Rank 0 is most recent; ranks always form a permutation.
    logic [IDXW-1:0] rank [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) rank[i] <= IDXW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < LINES; i++) begin
                if (IDXW'(i) == touch_idx)           rank[i] <= '0;
                else if (rank[i] < rank[touch_idx])  rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic [IDXW-1:0] best;
        best       = '0;
        victim_ok  = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!lock_vec[i] && (!victim_ok || rank[i] > best)) begin
                victim_ok  = 1'b1;
                victim_idx = IDXW'(i);
                best       = rank[i];
            end
        end
    end
endmodule

// File: rtl/lc_fill_ctrl.sv
module lc_fill_ctrl
    import lc_pkg::*;
#(
    parameter int unsigned LINES = 16,
    localparam int unsigned IDXW = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                miss_go,
    input  logic [LC_TAGW-1:0]  miss_tag,
    input  logic [LC_WSELW-1:0] miss_word,
    input  logic                miss_instr,
    input  logic [IDXW-1:0]     victim_idx,
    input  logic                victim_ok,
    input  logic [LINES-1:0]    pend_vec,
    input  lc_tag_t [LINES-1:0] tags,
    input  logic                mem_beat,
    input  logic [LC_DW-1:0]    mem_rdata,
    output logic                idle,
    output logic                mem_req,
    output logic [LC_AW-1:0]    mem_addr,
    output logic                wr_en,
    output logic [IDXW-1:0]     wr_line,
    output logic [LC_WSELW-1:0] wr_word,
    output logic                fill_done,
    output logic [IDXW-1:0]     done_line,
    output logic [LC_TAGW-1:0]  done_tag,
    output logic                done_instr,
    output logic                done_alloc,
    output logic                done_preload,
    output logic                rsp_valid,
    output logic [LC_DW-1:0]    rsp_data
);
    fc_state_t           state;
    logic [IDXW-1:0]     f_line, pend_idx;
    logic [LC_TAGW-1:0]  f_tag;
    logic [LC_WSELW-1:0] f_word, beat;
    logic                f_instr, f_alloc, f_pre;
    logic [LC_DW-1:0]    hold;

    always_comb begin
        pend_idx = '0;
        for (int i = LINES - 1; i >= 0; i--)
            if (pend_vec[i]) pend_idx = IDXW'(i);
    end

    assign idle      = (state == FC_IDLE);
    assign mem_req   = (state == FC_FILL);
    assign mem_addr  = {f_tag, {LC_OFFW{1'b0}}};
    assign wr_en     = mem_req && mem_beat && f_alloc;
    assign wr_line   = f_line;
    assign wr_word   = beat;
    assign fill_done = mem_req && mem_beat && (beat == LC_WSELW'(LC_WORDS - 1));
    assign done_line = f_line;
    assign done_tag  = f_tag;
    assign done_instr   = f_instr;
    assign done_alloc   = f_alloc;
    assign done_preload = f_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FC_IDLE;
            {f_line, f_tag, f_word, beat, f_instr, f_alloc, f_pre} <= '0;
            hold      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fill_done && !f_pre;
            if (fill_done) rsp_data <= (beat == f_word) ? mem_rdata : hold;
            case (state)
                FC_IDLE: begin
                    beat <= '0;
                    if (|pend_vec) begin
                        state   <= FC_FILL;
                        f_line  <= pend_idx;
                        f_tag   <= tags[pend_idx].tag;
                        f_instr <= tags[pend_idx].instr;
                        f_word  <= '0;
                        f_alloc <= 1'b1;
                        f_pre   <= 1'b1;
                    end else if (miss_go) begin
                        state   <= FC_FILL;
                        f_line  <= victim_idx;
                        f_tag   <= miss_tag;
                        f_instr <= miss_instr;
                        f_word  <= miss_word;
                        f_alloc <= victim_ok;
                        f_pre   <= 1'b0;
                    end
                end
                FC_FILL: begin
                    if (mem_beat) begin
                        beat <= beat + 1'b1;
                        if (beat == f_word) hold <= mem_rdata;
                        if (fill_done) state <= FC_IDLE;
                    end
                end
                default: state <= FC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lc_cache.sv
module lc_cache
    import lc_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned MASK_A = 10,
    parameter int unsigned MASK_B = 11,
    localparam int unsigned IDXW  = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [LC_AW-1:0]    lk_addr,
    input  logic                lk_instr,
    output logic                lk_ready,
    output logic                lk_hit,
    output logic [LC_DW-1:0]    lk_rdata,
    output logic                rsp_valid,
    output logic [LC_DW-1:0]    rsp_data,
    input  logic                tw_en,
    input  logic [IDXW-1:0]     tw_line,
    input  logic [LC_TAGW-1:0]  tw_tag,
    input  logic                tw_valid,
    input  logic                tw_lock,
    input  logic                tw_instr,
    input  logic                mw_en,
    input  logic [IDXW-1:0]     mw_line,
    input  logic [LC_TAGW-1:0]  mw_mask,
    output logic                mem_req,
    output logic [LC_AW-1:0]    mem_addr,
    input  logic                mem_beat,
    input  logic [LC_DW-1:0]    mem_rdata
);
    lc_tag_t [LINES-1:0] tag_q;
    logic [LC_DW-1:0]    data_q [LINES][LC_WORDS];
    logic [LINES-1:0]    pend_q, lock_vec;
    logic                hit_any, victim_ok, idle, miss_go;
    logic [IDXW-1:0]     hit_idx, victim_idx;
    logic                wr_en, fill_done, done_instr, done_alloc, done_preload;
    logic [IDXW-1:0]     wr_line, done_line;
    logic [LC_WSELW-1:0] wr_word;
    logic [LC_TAGW-1:0]  done_tag;

    for (genvar i = 0; i < LINES; i++) begin : g_lock
        assign lock_vec[i] = tag_q[i].lock;
    end

    assign lk_ready = idle && !(|pend_q);
    assign lk_hit   = lk_valid && lk_ready && hit_any;
    assign miss_go  = lk_valid && lk_ready && !hit_any;
    assign lk_rdata = lk_hit ? data_q[hit_idx][lk_addr[LC_OFFW-1:LC_OFFW-LC_WSELW]] : '0;

    lc_tag_match #(.LINES(LINES), .MASK_A(MASK_A), .MASK_B(MASK_B)) u_match (
        .clk(clk), .rst(rst), .tags(tag_q),
        .lk_tag(lk_addr[LC_AW-1:LC_OFFW]), .lk_instr(lk_instr),
        .mw_en(mw_en), .mw_line(mw_line), .mw_mask(mw_mask),
        .hit_any(hit_any), .hit_idx(hit_idx)
    );

    lc_lru #(.LINES(LINES)) u_lru (
        .clk(clk), .rst(rst),
        .touch_en(lk_hit || (fill_done && done_alloc)),
        .touch_idx(lk_hit ? hit_idx : done_line),
        .lock_vec(lock_vec), .victim_idx(victim_idx), .victim_ok(victim_ok)
    );

    lc_fill_ctrl #(.LINES(LINES)) u_fill (
        .clk(clk), .rst(rst), .miss_go(miss_go),
        .miss_tag(lk_addr[LC_AW-1:LC_OFFW]),
        .miss_word(lk_addr[LC_OFFW-1:LC_OFFW-LC_WSELW]), .miss_instr(lk_instr),
        .victim_idx(victim_idx), .victim_ok(victim_ok),
        .pend_vec(pend_q), .tags(tag_q),
        .mem_beat(mem_beat), .mem_rdata(mem_rdata),
        .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_line(wr_line), .wr_word(wr_word),
        .fill_done(fill_done), .done_line(done_line), .done_tag(done_tag),
        .done_instr(done_instr), .done_alloc(done_alloc), .done_preload(done_preload),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_line][wr_word] <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            pend_q <= '0;
        end else begin
            if (miss_go && victim_ok) tag_q[victim_idx].valid <= 1'b0;
            if (fill_done && done_alloc) begin
                tag_q[done_line].valid <= 1'b1;
                tag_q[done_line].instr <= done_instr;
                tag_q[done_line].tag   <= done_tag;
            end
            if (fill_done && done_preload) pend_q[done_line] <= 1'b0;
            if (tw_en) begin
                tag_q[tw_line]  <= '{valid: tw_valid, lock: tw_lock, instr: tw_instr, tag: tw_tag};
                pend_q[tw_line] <= tw_lock && !tw_valid;
            end
        end
    end
endmodule

// File: rtl/lc_cache_chk.sv
module lc_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        lk_hit,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_beat,
    input logic        rsp_valid,
    input logic        victim_ok,
    input logic        victim_lock
);
    p_hit_accepted_r11: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_valid && lk_ready));
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !lk_ready);
    p_line_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[3:0] == 4'd0));
    p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));
    p_rsp_after_beat_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_beat));
    p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
        victim_ok |-> !victim_lock);
endmodule

bind lc_cache lc_cache_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_hit(lk_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_beat(mem_beat), .rsp_valid(rsp_valid),
    .victim_ok(victim_ok), .victim_lock(tag_q[victim_idx].lock)
);

// File: tb/test_lc_cache.sv
module test_lc_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_instr = 0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, lk_hit, rsp_valid, mem_req;
    logic [31:0] lk_rdata, rsp_data, mem_addr;
    logic        tw_en = 0, tw_valid = 0, tw_lock = 0, tw_instr = 0;
    logic [3:0]  tw_line = '0, mw_line = '0;
    logic [27:0] tw_tag = '0, mw_mask = '0;
    logic        mw_en = 0;
    logic        mem_beat = 0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0, fill_cnt = 0, beat_cnt = 0;
    logic [31:0] last_fill = '0;
    logic [31:0] exp_q [$];
    bit finished = 0;

    always #2 clk = ~clk;

    lc_cache i_lc_cache (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_instr(lk_instr),
        .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_rdata(lk_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .tw_en(tw_en), .tw_line(tw_line), .tw_tag(tw_tag), .tw_valid(tw_valid),
        .tw_lock(tw_lock), .tw_instr(tw_instr),
        .mw_en(mw_en), .mw_line(mw_line), .mw_mask(mw_mask),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_beat(mem_beat), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memw(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_1E0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: four in-order beats per request.
    always @(negedge clk) begin
        if (!mem_req) begin
            beat_cnt = 0;
            mem_beat = 0;
        end else if (beat_cnt < 4) begin
            if (beat_cnt == 0) begin
                fill_cnt++;
                last_fill = mem_addr;
            end
            mem_beat  = 1;
            mem_rdata = memw(mem_addr + 32'(beat_cnt * 4));
            beat_cnt++;
        end else begin
            mem_beat = 0;
        end
    end

    // Scoreboard monitor for miss responses.
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected response", rsp_data, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e, "R3 response word", rsp_data, e);
            end
        end
    end

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        exp_q.delete();
    endtask

    task automatic wait_ready();
        while (!lk_ready) @(negedge clk);
    endtask

    // exp_hit: expected hit; dat_addr: address whose memory word is expected.
    task automatic lookup(input logic [31:0] a, input logic ins, input bit exp_hit,
                          input logic [31:0] dat_addr, input string req);
        int fc;
        wait_ready();
        @(negedge clk);
        fc = fill_cnt;
        lk_valid = 1; lk_addr = a; lk_instr = ins;
        #1;
        chk(lk_hit == exp_hit, req, {31'd0, lk_hit}, {31'd0, exp_hit});
        if (exp_hit) chk(lk_rdata == memw(dat_addr), req, lk_rdata, memw(dat_addr));
        else exp_q.push_back(memw(dat_addr));
        @(negedge clk);
        lk_valid = 0;
        if (!exp_hit && !lk_hit) begin
            chk(lk_ready == 0, "R11 busy during fill", {31'd0, lk_ready}, 32'd0);
            wait_ready();
            chk(last_fill == {a[31:4], 4'h0}, "R3 fill address", last_fill, {a[31:4], 4'h0});
            chk(fill_cnt == fc + 1, "R3 one fill per miss", fill_cnt, fc + 1);
        end
    endtask

    task automatic preload(input int line, input logic [31:0] a);
        int fc;
        wait_ready();
        @(negedge clk);
        fc = fill_cnt;
        tw_en = 1; tw_line = 4'(line); tw_tag = a[31:4];
        tw_valid = 0; tw_lock = 1; tw_instr = 0;
        @(negedge clk);
        tw_en = 0;
        #1;
        chk(lk_ready == 0, "R7 not ready while preloading", {31'd0, lk_ready}, 32'd0);
        wait_ready();
        @(negedge clk);
        chk(fill_cnt == fc + 1 && last_fill == {a[31:4], 4'h0}, "R7 preload fetch",
            last_fill, {a[31:4], 4'h0});
    endtask

    task automatic mask_wr(input int line, input logic [27:0] m);
        @(negedge clk);
        mw_en = 1; mw_line = 4'(line); mw_mask = m;
        @(negedge clk);
        mw_en = 0;
    endtask

    initial begin
        do_reset();
        // R1
        #1;
        chk(lk_ready == 1, "R1 ready after reset", {31'd0, lk_ready}, 32'd1);
        chk(mem_req == 0, "R1 no request after reset", {31'd0, mem_req}, 32'd0);
        lookup(32'h0000_1004, 0, 0, 32'h0000_1004, "R1 first lookup misses");
        // R2/R3
        lookup(32'h0000_1008, 0, 1, 32'h0000_1008, "R2 hit after fill");
        lookup(32'h0000_100C, 0, 1, 32'h0000_100C, "R2 hit word 3");
        lookup(32'h0000_2000, 0, 0, 32'h0000_2000, "R3 miss word 0");
        // R10
        lookup(32'h0000_1008, 1, 0, 32'h0000_1008, "R10 type mismatch misses");
        lookup(32'h0000_1000, 1, 1, 32'h0000_1000, "R10 instruction copy hits");
        // R11: lookup during a fill is ignored
        begin
            int fc;
            wait_ready();
            @(negedge clk);
            fc = fill_cnt;
            lk_valid = 1; lk_addr = 32'h0000_3004; lk_instr = 0;
            exp_q.push_back(memw(32'h0000_3004));
            @(negedge clk);
            lk_addr = 32'h0000_1008;
            #1;
            chk(lk_hit == 0, "R11 no hit while busy", {31'd0, lk_hit}, 32'd0);
            @(negedge clk);
            lk_addr = 32'h0000_5000;
            @(negedge clk);
            lk_valid = 0;
            wait_ready();
            @(negedge clk);
            chk(fill_cnt == fc + 1, "R11 no fill from ignored lookup", fill_cnt, fc + 1);
        end

        // R5: LRU order
        do_reset();
        for (int i = 0; i < 16; i++)
            lookup(32'h0001_0000 + 32'(i * 16), 0, 0, 32'h0001_0000 + 32'(i * 16), "R5 fill line");
        lookup(32'h0001_0000, 0, 1, 32'h0001_0000, "R5 touch oldest");
        lookup(32'h0002_0000, 0, 0, 32'h0002_0000, "R5 new miss");
        lookup(32'h0001_0000, 0, 1, 32'h0001_0000, "R5 touched line kept");
        lookup(32'h0001_0010, 0, 0, 32'h0001_0010, "R5 LRU line evicted");
        for (int i = 3; i < 16; i++)
            lookup(32'h0001_0000 + 32'(i * 16), 0, 1, 32'h0001_0000 + 32'(i * 16), "R5 others kept");

        // R7 / R6
        do_reset();
        preload(3, 32'h8000_0040);
        lookup(32'h8000_0044, 0, 1, 32'h8000_0044, "R7 preloaded line valid");
        for (int i = 0; i < 20; i++)
            lookup(32'h0003_0000 + 32'(i * 16), 0, 0, 32'h0003_0000 + 32'(i * 16), "R6 churn miss");
        lookup(32'h8000_0048, 0, 1, 32'h8000_0048, "R6 locked line survives");
        // R4: invalidate then refill
        @(negedge clk);
        tw_en = 1; tw_line = 4'd3; tw_tag = 28'h800_0004; tw_valid = 0; tw_lock = 0; tw_instr = 0;
        @(negedge clk);
        tw_en = 0;
        lookup(32'h8000_0040, 0, 0, 32'h8000_0040, "R4 invalid line misses");
        lookup(32'h8000_0040, 0, 1, 32'h8000_0040, "R4 refilled line hits");

        // R8: mask on line 10 aliases; mask on line 5 ignored
        do_reset();
        preload(10, 32'h0000_4000);
        mask_wr(10, 28'h000_0100);
        lookup(32'h0000_5004, 0, 1, 32'h0000_4004, "R8 masked alias hits");
        lookup(32'h0000_4008, 0, 1, 32'h0000_4008, "R8 base still hits");
        preload(5, 32'h0000_6000);
        mask_wr(5, 28'h000_0100);
        lookup(32'h0000_7000, 0, 0, 32'h0000_7000, "R8 mask on line 5 ignored");

        // R9: all lines locked
        do_reset();
        for (int i = 0; i < 16; i++) preload(i, 32'h0004_0000 + 32'(i * 16));
        lookup(32'h0009_0004, 0, 0, 32'h0009_0004, "R9 pass-through miss");
        lookup(32'h0009_0004, 0, 0, 32'h0009_0004, "R9 no allocation");
        lookup(32'h0004_0054, 0, 1, 32'h0004_0054, "R9 locked lines intact");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule